// File: doc/BRIEF.md
# Peripheral Register Access Guard

This block sits between a CPU-side register request and fourteen protected peripheral register spaces. Each space has its own read-protect bit and its own write-protect bit. An unprivileged request that hits a protected direction is stopped: the peripheral strobe stays low and read data comes back as zero. A privileged request always passes, whatever the masks hold.

One global mode bit decides how a stopped request is answered. With the bit clear the request is dropped without an error. With the bit set it is dropped and a bus error is returned. The decision is combinational, so grant, error, peripheral strobe and read data all appear in the same cycle as the request strobe.

The guard's own configuration is one of the fourteen protected spaces. It is reached through the same request port and the same check. Setting the guard's own write-protect bit therefore freezes its configuration against unprivileged code. The select input can be built as a binary index or as a one-hot vector, chosen by a parameter.

Top module: `periph_access_guard`

## Requirements
- R1: After reset all read masks, all write masks and the mode bit are zero, so every unprivileged access to any of the 14 spaces is granted without error.
- R2: An unprivileged read of a space whose read-protect bit is set is not granted, raises no peripheral strobe and returns zero on rsp_rdata.
- R3: An unprivileged write to a space whose write-protect bit is set is not granted, raises no peripheral strobe and keeps periph_we low.
- R4: The read and write masks act independently. A space protected only for writes still grants unprivileged reads, and a space protected only for reads still grants unprivileged writes.
- R5: A privileged request to any valid index is granted, whatever the masks hold.
- R6: A blocked request gives bus_err=0 when the mode bit is 0, and bus_err=1 when the mode bit is 1. bus_err and grant are never high together.
- R7: grant, bus_err, periph_en, periph_we and rsp_rdata follow the request in the same cycle. They are all zero while req_valid is low.
- R8: Index 9 is the guard's own space. req_reg selects one of its registers: 0 is the read mask in bits [13:0], 1 is the write mask in bits [13:0], and 2 is the mode bit in bit 0. A register read as 3 returns 0. A granted write changes the register from the next cycle on. A granted read returns the current value.
- R9: When write-protect bit 9 is set, an unprivileged write to the guard's own space is ignored, and the configuration read back afterwards is unchanged.
- R10: With the indexed select, the values 14 and 15 are not granted and return bus_err=1 in either mode.
- R11: A granted access to a space other than 9 raises only periph_en bit idx. Index 9 never raises a periph_en bit. A granted read of another space returns periph_rdata on rsp_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe |
| req_sel | input | SEL_W (4) | Target space, as an index or one-hot depending on ONEHOT_SEL |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = privileged requester |
| req_reg | input | 2 | Register select inside the guard's own space |
| req_wdata | input | DATA_W | Write data |
| periph_rdata | input | DATA_W | Read data from the selected peripheral |
| grant | output | 1 | Request allowed through |
| bus_err | output | 1 | Error response |
| periph_en | output | N_PERIPH | One-hot peripheral strobe |
| periph_we | output | 1 | Write qualifier for the strobe |
| rsp_rdata | output | DATA_W | Read data returned to the requester |

## Verification
The main check is run with four patterns: privileged against unprivileged, read against write on spaces that are masked in only one direction, both settings of the mode bit, and selects that fall outside the decoded range. Together they separate a mask bit that is applied to the wrong direction, a privilege bypass that is missing, and an error that fires in the wrong mode. Self-protection is shown by an unprivileged write to the mode register, followed by a privileged read-back of that register. A sweep over all fourteen indices checks the strobe position and the read-data path, and checks that the guard's own index is kept off the strobe bus.

// File: rtl/guard_pkg.sv
`timescale 1ns/1ps
package guard_pkg;
   // Registers inside the guard's own space
   typedef enum logic [1:0] {
      CFG_RD_MASK = 2'd0,
      CFG_WR_MASK = 2'd1,
      CFG_MODE    = 2'd2,
      CFG_RSVD    = 2'd3
   } cfg_reg_e;
endpackage

// File: rtl/guard_sel_decode.sv
`timescale 1ns/1ps
module guard_sel_decode #(
   parameter int N_PERIPH   = 14,
   parameter bit ONEHOT_SEL = 1'b0,
   localparam int IDX_W     = $clog2(N_PERIPH),
   localparam int SEL_W     = ONEHOT_SEL ? N_PERIPH : IDX_W
) (
   input  logic [SEL_W-1:0] sel,
   output logic             dec_ok,
   output logic [IDX_W-1:0] idx
);
   generate
      if (ONEHOT_SEL) begin : g_onehot
         always_comb begin
            idx = '0;
            for (int i = 0; i < N_PERIPH; i++) begin
               if (sel[i]) idx = idx | IDX_W'(i);
            end
         end
         assign dec_ok = $onehot(sel);
      end else begin : g_index
         assign idx    = sel;
         assign dec_ok = 32'(sel) < N_PERIPH;
      end
   endgenerate
endmodule

// File: rtl/guard_cfg_regs.sv
`timescale 1ns/1ps
module guard_cfg_regs
   import guard_pkg::*;
#(
   parameter int N_PERIPH = 14,
   parameter int DATA_W   = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  cfg_reg_e            reg_sel,
   input  logic [DATA_W-1:0]   wr_data,
   output logic [N_PERIPH-1:0] rd_mask,
   output logic [N_PERIPH-1:0] wr_mask,
   output logic                err_mode,
   output logic [DATA_W-1:0]   rd_word
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_mask  <= '0;
         wr_mask  <= '0;
         err_mode <= 1'b0;
      end else if (wr_en) begin
         case (reg_sel)
            CFG_RD_MASK: rd_mask  <= wr_data[N_PERIPH-1:0];
            CFG_WR_MASK: wr_mask  <= wr_data[N_PERIPH-1:0];
            CFG_MODE:    err_mode <= wr_data[0];
            default: ;
         endcase
      end
   end

   always_comb begin
      case (reg_sel)
         CFG_RD_MASK: rd_word = DATA_W'(rd_mask);
         CFG_WR_MASK: rd_word = DATA_W'(wr_mask);
         CFG_MODE:    rd_word = DATA_W'(err_mode);
         default:     rd_word = '0;
      endcase
   end

   // R8: configuration changes only through a granted write
   p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(rd_mask) && $stable(wr_mask) && $stable(err_mode)));
endmodule

// File: rtl/guard_policy.sv
`timescale 1ns/1ps
module guard_policy #(
   parameter int N_PERIPH = 14,
   localparam int IDX_W   = $clog2(N_PERIPH)
) (
   input  logic                valid,
   input  logic                write,
   input  logic                priv,
   input  logic                dec_ok,
   input  logic [IDX_W-1:0]    idx,
   input  logic [N_PERIPH-1:0] rd_mask,
   input  logic [N_PERIPH-1:0] wr_mask,
   input  logic                err_mode,
   output logic                grant,
   output logic                bus_err
);
   logic prot_hit;
   logic blocked;

   always_comb begin
      prot_hit = 1'b0;
      if (dec_ok) prot_hit = write ? wr_mask[idx] : rd_mask[idx];
      blocked  = !dec_ok || (!priv && prot_hit);
      grant    = valid && !blocked;
      bus_err  = valid && (!dec_ok || (!priv && prot_hit && err_mode));
   end
endmodule

// File: rtl/periph_access_guard.sv
`timescale 1ns/1ps
module periph_access_guard
   import guard_pkg::*;
#(
   parameter int N_PERIPH   = 14,
   parameter int DATA_W     = 32,
   parameter int SELF_IDX   = 9,
   parameter bit ONEHOT_SEL = 1'b0,
   localparam int IDX_W     = $clog2(N_PERIPH),
   localparam int SEL_W     = ONEHOT_SEL ? N_PERIPH : IDX_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [SEL_W-1:0]    req_sel,
   input  logic                req_write,
   input  logic                req_priv,
   input  logic [1:0]          req_reg,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic [DATA_W-1:0]   periph_rdata,
   output logic                grant,
   output logic                bus_err,
   output logic [N_PERIPH-1:0] periph_en,
   output logic                periph_we,
   output logic [DATA_W-1:0]   rsp_rdata
);
   generate
      if (N_PERIPH < 2)        begin : g_bad_n    $error("N_PERIPH must be at least 2"); end
      if (SELF_IDX >= N_PERIPH) begin : g_bad_self $error("SELF_IDX out of range"); end
      if (DATA_W < N_PERIPH)   begin : g_bad_w    $error("DATA_W must hold a mask"); end
   endgenerate

   logic                dec_ok;
   logic [IDX_W-1:0]    idx;
   logic [N_PERIPH-1:0] rd_mask, wr_mask;
   logic                err_mode;
   logic [DATA_W-1:0]   cfg_word;
   logic                self_hit;
   logic                cfg_wr_en;

   guard_sel_decode #(.N_PERIPH(N_PERIPH), .ONEHOT_SEL(ONEHOT_SEL)) i_dec (
      .sel(req_sel), .dec_ok(dec_ok), .idx(idx));

   guard_policy #(.N_PERIPH(N_PERIPH)) i_pol (
      .valid(req_valid), .write(req_write), .priv(req_priv),
      .dec_ok(dec_ok), .idx(idx), .rd_mask(rd_mask), .wr_mask(wr_mask),
      .err_mode(err_mode), .grant(grant), .bus_err(bus_err));

   assign self_hit  = dec_ok && (32'(idx) == SELF_IDX);
   assign cfg_wr_en = grant && req_write && self_hit;

   guard_cfg_regs #(.N_PERIPH(N_PERIPH), .DATA_W(DATA_W)) i_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en),
      .reg_sel(cfg_reg_e'(req_reg)), .wr_data(req_wdata),
      .rd_mask(rd_mask), .wr_mask(wr_mask), .err_mode(err_mode),
      .rd_word(cfg_word));

   genvar gi;
   generate
      for (gi = 0; gi < N_PERIPH; gi++) begin : g_strobe
         if (gi == SELF_IDX) begin : g_self
            assign periph_en[gi] = 1'b0;
         end else begin : g_ext
            assign periph_en[gi] = grant && (32'(idx) == gi);
         end
      end
   endgenerate

   assign periph_we = grant && req_write;
   assign rsp_rdata = (grant && !req_write) ? (self_hit ? cfg_word : periph_rdata) : '0;

   // R5: privilege bypasses every mask
   p_priv_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_priv && dec_ok) |-> grant);
   // R6: error and grant exclude each other
   p_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> !grant);
   // R7: idle request leaves every output quiet
   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (!grant && !bus_err && periph_en == '0 && !periph_we && rsp_rdata == '0));
   // R11: at most one strobe, never on the guard's own index
   p_strobe_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(periph_en) && !periph_en[SELF_IDX]);
   // R2: a refused read returns zero
   p_blocked_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && !grant) |-> rsp_rdata == '0);
endmodule

// File: tb/test_periph_access_guard.sv
`timescale 1ns/1ps
module test_periph_access_guard;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [3:0]  req_sel = '0;
   logic        req_write = 1'b0;
   logic        req_priv = 1'b0;
   logic [1:0]  req_reg = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] periph_rdata = '0;
   logic        grant, bus_err, periph_we;
   logic [13:0] periph_en;
   logic [31:0] rsp_rdata;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // reference state
   logic [13:0] m_rd = '0;
   logic [13:0] m_wr = '0;
   bit          m_mode = 1'b0;

   always #5 clk = ~clk;

   periph_access_guard i_periph_access_guard (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
      .req_write(req_write), .req_priv(req_priv), .req_reg(req_reg),
      .req_wdata(req_wdata), .periph_rdata(periph_rdata), .grant(grant),
      .bus_err(bus_err), .periph_en(periph_en), .periph_we(periph_we),
      .rsp_rdata(rsp_rdata));

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] cfg_val(input logic [1:0] r);
      case (r)
         2'd0: return {18'd0, m_rd};
         2'd1: return {18'd0, m_wr};
         2'd2: return {31'd0, m_mode};
         default: return 32'd0;
      endcase
   endfunction

   task automatic step(input bit v, input int sel, input bit wr, input bit pv,
                       input logic [1:0] r, input logic [31:0] wd, input logic [31:0] pd,
                       input string tag);
      bit e_dec, e_prot, e_grant, e_err, e_we;
      logic [13:0] e_en;
      logic [31:0] e_rd;
      @(negedge clk);
      req_valid = v; req_sel = 4'(sel); req_write = wr; req_priv = pv;
      req_reg = r; req_wdata = wd; periph_rdata = pd;
      #2;
      e_dec   = sel < 14;
      e_prot  = e_dec && (wr ? m_wr[sel] : m_rd[sel]);
      e_grant = v && e_dec && (pv || !e_prot);
      e_err   = v && (!e_dec || (!pv && e_prot && m_mode));
      e_we    = e_grant && wr;
      e_en    = (e_grant && sel != 9) ? (14'd1 << sel) : 14'd0;
      e_rd    = (e_grant && !wr) ? ((sel == 9) ? cfg_val(r) : pd) : 32'd0;
      chk(tag, "grant", 32'(grant), 32'(e_grant));
      chk(tag, "bus_err", 32'(bus_err), 32'(e_err));
      chk(tag, "periph_en", 32'(periph_en), 32'(e_en));
      chk(tag, "periph_we", 32'(periph_we), 32'(e_we));
      chk(tag, "rsp_rdata", rsp_rdata, e_rd);
      @(posedge clk);
      if (e_grant && wr && sel == 9) begin
         case (r)
            2'd0: m_rd = wd[13:0];
            2'd1: m_wr = wd[13:0];
            2'd2: m_mode = wd[0];
            default: ;
         endcase
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // R7 idle, R1 reset state
      step(0, 3, 0, 0, 0, 0, 32'h11, "R7");
      step(1, 3, 0, 0, 0, 0, 32'hA5A5, "R1");
      step(1, 13, 1, 0, 0, 0, 0, "R1");
      step(1, 9, 0, 0, 2'd0, 0, 0, "R1");
      // R8 configure read mask bits 3 and 5
      step(1, 9, 1, 1, 2'd0, 32'h28, 0, "R8");
      step(1, 9, 0, 1, 2'd0, 0, 0, "R8");
      // R2 blocked read, mode 0 gives no error (R6)
      step(1, 3, 0, 0, 0, 0, 32'hDEAD, "R2");
      step(1, 5, 0, 0, 0, 0, 32'hBEEF, "R6");
      // R4 write still allowed on read-only-protected space
      step(1, 3, 1, 0, 0, 32'h1, 0, "R4");
      // write mask bits 7 and 9
      step(1, 9, 1, 1, 2'd1, 32'h280, 0, "R8");
      step(1, 7, 1, 0, 0, 32'h5, 0, "R3");
      step(1, 7, 0, 0, 0, 0, 32'h77, "R4");
      // R5 privilege bypass
      step(1, 3, 0, 1, 0, 0, 32'h1234, "R5");
      step(1, 7, 1, 1, 0, 32'h9, 0, "R5");
      // R9 self write protection
      step(1, 9, 1, 0, 2'd2, 32'h1, 0, "R9");
      step(1, 9, 1, 0, 2'd0, 32'h0, 0, "R9");
      step(1, 9, 0, 1, 2'd2, 0, 0, "R9");
      step(1, 9, 0, 1, 2'd0, 0, 0, "R9");
      // R8 unprivileged read of config (read of space 9 not protected)
      step(1, 9, 0, 0, 2'd1, 0, 0, "R8");
      step(1, 9, 0, 0, 2'd3, 0, 0, "R8");
      // R6 error mode on
      step(1, 9, 1, 1, 2'd2, 32'h1, 0, "R6");
      step(1, 5, 0, 0, 0, 0, 32'h55, "R6");
      step(1, 7, 1, 0, 0, 32'h2, 0, "R6");
      step(1, 7, 0, 0, 0, 0, 32'h66, "R6");
      // R10 out-of-range selects in both modes
      step(1, 14, 0, 1, 0, 0, 32'h1, "R10");
      step(1, 15, 1, 0, 0, 32'h1, 0, "R10");
      step(1, 9, 1, 1, 2'd2, 32'h0, 0, "R10");
      step(1, 15, 0, 1, 0, 0, 32'h1, "R10");
      step(1, 14, 1, 1, 0, 32'h1, 0, "R10");
      // R11 sweep over every index
      for (int i = 0; i < 14; i++) begin
         step(1, i, 0, 1, 2'd1, 0, 32'h100 + 32'(i), "R11");
         step(1, i, 1, 1, 2'd3, 32'h0, 0, "R11");
      end
      step(0, 2, 1, 1, 0, 32'hF, 32'hF, "R7");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule